// File: doc/BRIEF.md
# Collision-Priority Control Register Block

This block is a small control and status register block on a simple CPU bus. It holds two one-bit control fields. Software can write them from the bus, and hardware can load them through a next-value input gated by a per-field enable. When both sources load the same field in the same clock cycle, a fixed rule picks the winner. On field A (bit 0) the software value wins. On field B (bit 1) the hardware value wins.

A second register is read-only. It holds two 4-bit event counters. Each counter advances on every clock edge at which its field holds 1. Software can therefore see the effect of the collision rule as a count, without probing the fields directly. The current field values are also driven out to the surrounding logic.

Every bus request completes exactly one cycle after it is presented. Every access covers the full 32-bit word. The two register offsets are word aligned.

Top module: `prio_regblock`

## Requirements
- R1: Reset is synchronous and active-high. During reset and after it, both fields read 0, both counters read 0 and `ready` is 0.
- R2: Field A is bit 0 of the control register at offset 0x0. When a software write to 0x0 and `hw_a_we` fall in the same cycle, field A takes `wdata[0]`.
- R3: Field B is bit 1 of the control register at offset 0x0. When a software write to 0x0 and `hw_b_we` fall in the same cycle, field B takes `hw_b_next`.
- R4: Without a collision, a software write to 0x0 loads `wdata[0]` into field A and `wdata[1]` into field B. An enabled hardware write loads its next value. With neither source active, a field holds its value. A read of 0x0 returns {30'b0, B, A}.
- R5: The event register is at offset 0x4. Bits [3:0] count clock edges at which field A was 1, and bits [7:4] count clock edges at which field B was 1. The upper bits read 0.
- R6: Each 4-bit counter wraps from 15 to 0.
- R7: A software write to offset 0x4 leaves both counters unchanged.
- R8: A read of any offset other than 0x0 or 0x4 returns 0 and still completes.
- R9: `ready` is 1 in the cycle after each cycle with `req` high, and 0 otherwise. `rdata` of a read is valid in that cycle.
- R10: Hardware holds both enables high with next value 0, and software writes 0b11 to 0x0 three times. The control register then reads 0 and the event register reads 0x03.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request, one cycle per access |
| wr_en | input | 1 | 1 for a write, 0 for a read |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with ready |
| ready | output | 1 | Access completion, one cycle after req |
| hw_a_we | input | 1 | Hardware load enable for field A |
| hw_a_next | input | 1 | Hardware next value for field A |
| hw_b_we | input | 1 | Hardware load enable for field B |
| hw_b_next | input | 1 | Hardware next value for field B |
| fld_a | output | 1 | Current value of field A |
| fld_b | output | 1 | Current value of field B |

## Verification
The assertions assume that every offset presented with `req` is word aligned. They also assume that the bus inputs and the hardware load inputs are driven to known values from the first clock edge of reset onward. The stimulus draws addresses only from the four aligned offsets 0x0, 0x4, 0x8 and 0xC. It drives every input from the first cycle, with random hardware enables and values, so collisions on both fields occur often.

// File: rtl/prio_regblock.sv
module prio_regblock #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  input  logic              hw_a_we,
  input  logic              hw_a_next,
  input  logic              hw_b_we,
  input  logic              hw_b_next,
  output logic              fld_a,
  output logic              fld_b
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = '0;
  localparam logic [ADDR_W-1:0] OFF_EVT  = ADDR_W'(4);

  logic             sel_ctrl, sel_evt, sw_wr_ctrl;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic [DATA_W-1:0] rd_val;
  logic             unused_wdata;

  assign sel_ctrl     = (addr == OFF_CTRL);
  assign sel_evt      = (addr == OFF_EVT);
  assign sw_wr_ctrl   = req && wr_en && sel_ctrl;
  assign unused_wdata = ^wdata[DATA_W-1:2];

  assign rd_val = sel_ctrl ? DATA_W'({fld_b, fld_a}) :
                  sel_evt  ? DATA_W'({cnt_b, cnt_a}) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_a <= 1'b0;
      fld_b <= 1'b0;
      cnt_a <= '0;
      cnt_b <= '0;
    end else begin
      if (sw_wr_ctrl)   fld_a <= wdata[0];
      else if (hw_a_we) fld_a <= hw_a_next;
      if (hw_b_we)         fld_b <= hw_b_next;
      else if (sw_wr_ctrl) fld_b <= wdata[1];
      cnt_a <= cnt_a + CNT_W'(fld_a);
      cnt_b <= cnt_b + CNT_W'(fld_b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= req;
      rdata <= (req && !wr_en) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/prio_regblock_chk.sv
module prio_regblock_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wd0,
  input logic [DATA_W-1:0] rdata,
  input logic              ready,
  input logic              hw_a_we,
  input logic              hw_a_next,
  input logic              hw_b_we,
  input logic              hw_b_next,
  input logic              fld_a,
  input logic              fld_b
);
  logic ctrl_wr;
  assign ctrl_wr = req && wr_en && (addr == '0);

  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (rst)
    req |=> ready);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ready);
  assert_sw_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && hw_a_we) |=> (fld_a == $past(wd0)));
  assert_hw_wins_R3: assert property (@(posedge clk) disable iff (rst)
    hw_b_we |=> (fld_b == $past(hw_b_next)));
  assert_hold_a_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !hw_a_we) |=> $stable(fld_a));
  assert_hold_b_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !hw_b_we) |=> $stable(fld_b));
  assert_hw_load_a_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && hw_a_we) |=> (fld_a == $past(hw_a_next)));
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !wr_en && addr != '0 && addr != ADDR_W'(4)) |=> (ready && rdata == '0));
endmodule

bind prio_regblock prio_regblock_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr), .wd0(wdata[0]),
  .rdata(rdata), .ready(ready), .hw_a_we(hw_a_we), .hw_a_next(hw_a_next),
  .hw_b_we(hw_b_we), .hw_b_next(hw_b_next), .fld_a(fld_a), .fld_b(fld_b)
);

// File: tb/sim_prio_regblock.sv
`timescale 1ns/1ps
module sim_prio_regblock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        hw_a_we = 1'b0, hw_a_next = 1'b0, hw_b_we = 1'b0, hw_b_next = 1'b0;
  logic        fld_a, fld_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic       ma, mb;
  logic [3:0] mca, mcb;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  prio_regblock u0 (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .hw_a_we(hw_a_we), .hw_a_next(hw_a_next),
    .hw_b_we(hw_b_we), .hw_b_next(hw_b_next), .fld_a(fld_a), .fld_b(fld_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a == 4'h0) return {30'b0, mb, ma};
    if (a == 4'h4) return {24'b0, mcb, mca};
    return 32'h0;
  endfunction

  task automatic step(input logic r, input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic awe, input logic an, input logic bwe, input logic bn);
    logic [31:0] exp_rd;
    logic sw, na, nb;
    req = r; wr_en = w; addr = a; wdata = d;
    hw_a_we = awe; hw_a_next = an; hw_b_we = bwe; hw_b_next = bn;
    exp_rd = model_read(a);
    sw = r && w && (a == 4'h0);
    na = sw ? d[0] : (awe ? an : ma);
    nb = bwe ? bn : (sw ? d[1] : mb);
    mca = mca + 4'(ma);
    mcb = mcb + 4'(mb);
    ma = na; mb = nb;
    @(posedge clk); #1;
    chk(ready == r, "R9 ready", 32'(ready), 32'(r));
    if (r && !w) begin
      last_rd = rdata;
      chk(rdata == exp_rd, (a == 4'h0) ? "R4 ctrl read" : (a == 4'h4) ? "R5 event read" : "R8 unmapped read",
          rdata, exp_rd);
    end
    chk(fld_a == ma, (sw && awe) ? "R2 field A" : "R4 field A", 32'(fld_a), 32'(ma));
    chk(fld_b == mb, (sw && bwe) ? "R3 field B" : "R4 field B", 32'(fld_b), 32'(mb));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req = 0; wr_en = 0; hw_a_we = 0; hw_b_we = 0;
    repeat (3) @(posedge clk);
    #1;
    ma = 0; mb = 0; mca = 0; mcb = 0;
    chk(ready == 1'b0 && fld_a == 1'b0 && fld_b == 1'b0, "R1 reset state",
        {29'b0, ready, fld_b, fld_a}, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v1;
    void'($urandom(32'd20220228));
    do_reset();
    step(1, 0, 4'h4, 0, 0, 0, 0, 0);
    chk(rdata == 32'h0, "R1 counters after reset", rdata, 32'h0);

    // R10 scenario
    step(0, 0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    step(1, 0, 4'h0, 0, 1, 0, 1, 0);
    step(1, 0, 4'h4, 0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 4'h0, 32'h3, 1, 0, 1, 0);
      step(0, 0, 0, 0, 1, 0, 1, 0);
    end
    step(1, 0, 4'h0, 0, 1, 0, 1, 0);
    chk(rdata == 32'h0, "R10 ctrl reads 0", rdata, 32'h0);
    step(1, 0, 4'h4, 0, 1, 0, 1, 0);
    chk(rdata == 32'h3, "R10 event reads 0x03", rdata, 32'h3);

    // R7: write to event register is ignored
    step(1, 0, 4'h4, 0, 1, 0, 1, 0);
    v1 = rdata;
    step(1, 1, 4'h4, 32'hFFFF_FFFF, 1, 0, 1, 0);
    step(1, 0, 4'h4, 0, 1, 0, 1, 0);
    chk(rdata == v1, "R7 event write ignored", rdata, v1);

    // R8: unmapped offsets
    step(1, 0, 4'h8, 0, 0, 0, 0, 0);
    chk(rdata == 32'h0 && ready, "R8 offset 0x8", rdata, 32'h0);
    step(1, 0, 4'hC, 0, 0, 0, 0, 0);
    chk(rdata == 32'h0 && ready, "R8 offset 0xC", rdata, 32'h0);

    // R6: wrap after 16 increments
    step(0, 0, 0, 0, 1, 1, 1, 1);
    step(1, 0, 4'h4, 0, 1, 1, 1, 1);
    v1 = rdata;
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 1, 1, 1, 1);
    step(1, 0, 4'h4, 0, 1, 1, 1, 1);
    chk(rdata == v1, "R6 counters wrap", rdata, v1);

    // R2/R3 directed collisions with opposing values
    step(1, 1, 4'h0, 32'h1, 1, 0, 1, 1);
    chk(fld_a == 1'b1 && fld_b == 1'b1, "R2 R3 collision", {30'b0, fld_b, fld_a}, 32'h3);
    step(1, 1, 4'h0, 32'h2, 1, 1, 1, 0);
    chk(fld_a == 1'b0 && fld_b == 1'b0, "R2 R3 collision", {30'b0, fld_b, fld_a}, 32'h0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 3) * 4);
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom(),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    do_reset();
    step(1, 0, 4'h4, 0, 0, 0, 0, 0);
    chk(rdata == 32'h0, "R1 counters after second reset", rdata, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule